// File: doc/BRIEF.md
# ECC Error Statistics and Capture Logger

This block sits behind an ECC decoder and watches its result for each transfer. A valid strobe marks each decoded transfer. Two flags with it say whether a single correctable error or an uncorrectable error was seen. The block keeps two 8-bit saturating counts, one for each error class. It also freezes a snapshot of the first uncorrectable transfer: the data word, the check byte and the corrected-bit mask. The snapshot is held until software re-arms the logger.

Software reads the results through a combinational word-indexed read port. It clears the counts and the snapshot by writing to a two-bit control register. Index 0 is the control register and indices 1 to 7 are status registers. Only the low data byte, the low five check bits and the low mask byte are kept. Every other captured bit reads back as zero.

Top module: `ecc_err_logger`

## Requirements
- R1: The statistics register at read index 1 holds the uncorrectable count in bits 7:0 and the correctable count in bits 15:8. Bits 31:16 read 0.
- R2: When `ev_valid` is high, each cycle with `ev_uncorr` high adds one to the uncorrectable count and each cycle with `ev_corr` high adds one to the correctable count. Both may count in the same cycle. The flags have no effect while `ev_valid` is low. Counts are readable in the cycle after the event edge.
- R3: Each count holds at 255 on further events and never wraps to 0.
- R4: A write to index 0 with `wr_data[0]`=1 clears the uncorrectable count. A write with `wr_data[1]`=1 clears the correctable count. A clear leaves the other count unchanged.
- R5: The first uncorrectable event while the log is empty sets the log-valid flag (bit 0 of index 2) and captures that transfer's word and mask.
- R6: While log-valid is set, later uncorrectable events leave the captured word, check bits and mask unchanged.
- R7: A control write with `wr_data[0]`=1 clears log-valid and zeroes the captured fields. The next uncorrectable event is then captured.
- R8: Index 3 returns captured data bits 7:0 in its bits 7:0. Index 5 returns captured check bits 4:0 in its bits 4:0. Index 4 and all other bits of indices 3 and 5 read 0.
- R9: Index 6 returns the captured corrected-bit mask (1 means corrected) in bits 7:0. Index 7 and bits 31:8 of index 6 read 0.
- R10: If an event and a clear of the same count or log fall in the same cycle, the clear wins and the event is dropped.
- R11: After reset every index reads 0. Index 0 always reads 0. Writes to indices other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Decoder result valid this cycle |
| ev_corr | input | 1 | Correctable error flag |
| ev_uncorr | input | 1 | Uncorrectable error flag |
| ev_data | input | 64 | Data part of the decoded word |
| ev_check | input | 8 | Check-bit part of the decoded word |
| ev_mask | input | 64 | Corrected-bit mask, 1 = bit corrected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 2 | Control write data (bit 0 uncorrectable/log clear, bit 1 correctable clear) |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |

## Verification
A transfer carrying both flags shows that the two counts advance independently. Flags raised without the valid strobe show whether the strobe gates them. The capture word is all ones with a distinctive low byte, so any leak of the unkept bits or a slip in the byte position shows up at once. A second, different uncorrectable word separates a frozen log from one that keeps overwriting. Clears that land with an event, clears of a single bit, and a long burst past 255 separate clear priority, independent clearing and saturation from wrap-around.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int DATA_W  = 64;
  localparam int CHECK_W = 8;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int CTRL_W  = 2;
  localparam int CNT_W   = 8;
  localparam int KEEP_DATA  = 8;
  localparam int KEEP_CHECK = 5;
  localparam int KEEP_MASK  = 8;

  typedef enum logic [ADDR_W-1:0] {
    IDX_CTRL   = 3'd0,
    IDX_STAT   = 3'd1,
    IDX_LOGV   = 3'd2,
    IDX_DAT_LO = 3'd3,
    IDX_DAT_HI = 3'd4,
    IDX_CHK    = 3'd5,
    IDX_MSK_LO = 3'd6,
    IDX_MSK_HI = 3'd7
  } reg_idx_e;

  localparam int CLR_UNCORR_BIT = 0;
  localparam int CLR_CORR_BIT   = 1;

  // Ones in the low n bits of a data-width vector.
  function automatic logic [DATA_W-1:0] low_ones_data(int n);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W; i++) v[i] = (i < n);
    return v;
  endfunction

  function automatic logic [CHECK_W-1:0] low_ones_check(int n);
    logic [CHECK_W-1:0] v;
    for (int i = 0; i < CHECK_W; i++) v[i] = (i < n);
    return v;
  endfunction
endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_step(logic [W-1:0] c, logic up);
    if (!up || c == TOP) return c;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= sat_step(count, inc);
  end
endmodule

// File: rtl/ecc_capture_log.sv
module ecc_capture_log
  import ecc_log_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               hit,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [CHECK_W-1:0] check_in,
  input  logic [DATA_W-1:0]  mask_in,
  output logic               fire,
  output logic               valid,
  output logic [DATA_W-1:0]  data_q,
  output logic [CHECK_W-1:0] check_q,
  output logic [DATA_W-1:0]  mask_q
);
  localparam logic [DATA_W-1:0]  DATA_KEEP  = low_ones_data(KEEP_DATA);
  localparam logic [CHECK_W-1:0] CHECK_KEEP = low_ones_check(KEEP_CHECK);
  localparam logic [DATA_W-1:0]  MASK_KEEP  = low_ones_data(KEEP_MASK);

  assign fire = hit && !valid && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; data_q <= '0; check_q <= '0; mask_q <= '0;
    end else if (clr) begin
      valid <= 1'b0; data_q <= '0; check_q <= '0; mask_q <= '0;
    end else if (fire) begin
      valid   <= 1'b1;
      data_q  <= data_in & DATA_KEEP;
      check_q <= check_in & CHECK_KEEP;
      mask_q  <= mask_in & MASK_KEEP;
    end
  end
endmodule

// File: rtl/ecc_log_readmux.sv
module ecc_log_readmux
  import ecc_log_pkg::*;
(
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [CNT_W-1:0]   uncorr_cnt,
  input  logic [CNT_W-1:0]   corr_cnt,
  input  logic               log_valid,
  input  logic [DATA_W-1:0]  log_data,
  input  logic [CHECK_W-1:0] log_check,
  input  logic [DATA_W-1:0]  log_mask,
  output logic [REG_W-1:0]   rd_data
);
  localparam int STAT_PAD = REG_W - 2*CNT_W;

  always_comb begin
    unique case (reg_idx_e'(rd_addr))
      IDX_CTRL:   rd_data = '0;
      IDX_STAT:   rd_data = {{STAT_PAD{1'b0}}, corr_cnt, uncorr_cnt};
      IDX_LOGV:   rd_data = {{(REG_W-1){1'b0}}, log_valid};
      IDX_DAT_LO: rd_data = log_data[REG_W-1:0];
      IDX_DAT_HI: rd_data = log_data[2*REG_W-1:REG_W];
      IDX_CHK:    rd_data = {{(REG_W-CHECK_W){1'b0}}, log_check};
      IDX_MSK_LO: rd_data = log_mask[REG_W-1:0];
      IDX_MSK_HI: rd_data = log_mask[2*REG_W-1:REG_W];
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic               ev_corr,
  input  logic               ev_uncorr,
  input  logic [DATA_W-1:0]  ev_data,
  input  logic [CHECK_W-1:0] ev_check,
  input  logic [DATA_W-1:0]  ev_mask,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data
);
  // Named internal events, observed by the bound checker.
  logic ctrl_wr, clr_uncorr, clr_corr;
  logic uncorr_hit, corr_hit, capture_fire;
  logic [CNT_W-1:0]   uncorr_cnt, corr_cnt;
  logic               log_valid;
  logic [DATA_W-1:0]  log_data, log_mask;
  logic [CHECK_W-1:0] log_check;

  assign ctrl_wr    = wr_en && (reg_idx_e'(wr_addr) == IDX_CTRL);
  assign clr_uncorr = ctrl_wr && wr_data[CLR_UNCORR_BIT];
  assign clr_corr   = ctrl_wr && wr_data[CLR_CORR_BIT];
  assign uncorr_hit = ev_valid && ev_uncorr;
  assign corr_hit   = ev_valid && ev_corr;

  ecc_sat_counter #(.W(CNT_W)) u_cnt_uncorr (
    .clk(clk), .rst_n(rst_n), .clr(clr_uncorr), .inc(uncorr_hit), .count(uncorr_cnt)
  );

  ecc_sat_counter #(.W(CNT_W)) u_cnt_corr (
    .clk(clk), .rst_n(rst_n), .clr(clr_corr), .inc(corr_hit), .count(corr_cnt)
  );

  ecc_capture_log u_log (
    .clk(clk), .rst_n(rst_n), .clr(clr_uncorr), .hit(uncorr_hit),
    .data_in(ev_data), .check_in(ev_check), .mask_in(ev_mask),
    .fire(capture_fire), .valid(log_valid),
    .data_q(log_data), .check_q(log_check), .mask_q(log_mask)
  );

  ecc_log_readmux u_rd (
    .rd_addr(rd_addr), .uncorr_cnt(uncorr_cnt), .corr_cnt(corr_cnt),
    .log_valid(log_valid), .log_data(log_data), .log_check(log_check),
    .log_mask(log_mask), .rd_data(rd_data)
  );
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk
  import ecc_log_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clr_uncorr,
  input logic               clr_corr,
  input logic               uncorr_hit,
  input logic               corr_hit,
  input logic               capture_fire,
  input logic [CNT_W-1:0]   uncorr_cnt,
  input logic [CNT_W-1:0]   corr_cnt,
  input logic               log_valid,
  input logic [DATA_W-1:0]  log_data,
  input logic [CHECK_W-1:0] log_check,
  input logic [DATA_W-1:0]  log_mask,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [REG_W-1:0]   rd_data
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_uncorr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_hit && !clr_uncorr && uncorr_cnt != TOP |=> uncorr_cnt == $past(uncorr_cnt) + 1'b1);

  assert_corr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    corr_hit && !clr_corr && corr_cnt != TOP |=> corr_cnt == $past(corr_cnt) + 1'b1);

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_cnt == TOP && !clr_uncorr |=> uncorr_cnt == TOP);

  assert_corr_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    corr_cnt == TOP && !clr_corr |=> corr_cnt == TOP);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_uncorr |=> uncorr_cnt == '0 && !log_valid);

  assert_corr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_corr && !clr_uncorr |=> uncorr_cnt == $past(uncorr_cnt) || uncorr_cnt == $past(uncorr_cnt) + 1'b1);

  assert_capture_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_fire |=> log_valid);

  assert_log_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && !clr_uncorr |=> $stable(log_data) && $stable(log_check) && $stable(log_mask) && log_valid);

  assert_high_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 3'd4 |-> rd_data == '0);

  assert_high_mask_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 3'd7 |-> rd_data == '0);
endmodule

bind ecc_err_logger ecc_err_logger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_uncorr(clr_uncorr), .clr_corr(clr_corr),
  .uncorr_hit(uncorr_hit), .corr_hit(corr_hit), .capture_fire(capture_fire),
  .uncorr_cnt(uncorr_cnt), .corr_cnt(corr_cnt), .log_valid(log_valid),
  .log_data(log_data), .log_check(log_check), .log_mask(log_mask),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/ecc_err_logger_tb_top.sv
module ecc_err_logger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 0, ev_corr = 0, ev_uncorr = 0;
  logic [63:0] ev_data = '0, ev_mask = '0;
  logic [7:0]  ev_check = '0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [1:0]  wr_data = '0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_err_logger dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_corr(ev_corr),
    .ev_uncorr(ev_uncorr), .ev_data(ev_data), .ev_check(ev_check),
    .ev_mask(ev_mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd_check(string req, logic [2:0] idx, logic [31:0] exp);
    rd_addr = idx;
    #0.5;
    check(req, rd_data, exp);
  endtask

  // One clock: optional event plus optional control write, results visible at next negedge.
  task automatic cycle(logic v, logic c, logic u, logic [63:0] d, logic [7:0] k,
                       logic [63:0] m, logic we, logic [2:0] wa, logic [1:0] wd);
    @(negedge clk);
    ev_valid = v; ev_corr = c; ev_uncorr = u; ev_data = d; ev_check = k; ev_mask = m;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(negedge clk);
    ev_valid = 0; ev_corr = 0; ev_uncorr = 0; wr_en = 0;
  endtask

  task automatic clear_all();
    cycle(0, 0, 0, '0, '0, '0, 1, 3'd0, 2'b11);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) rd_check("R11 reset", 3'(i), 32'h0);
  endtask

  task automatic t_counts();
    cycle(1, 1, 0, '0, '0, '0, 0, 0, 0);
    rd_check("R1 R2 corr count", 3'd1, 32'h0000_0100);
    cycle(1, 1, 1, '0, '0, '0, 0, 0, 0);
    rd_check("R2 both flags", 3'd1, 32'h0000_0201);
    cycle(0, 1, 1, '0, '0, '0, 0, 0, 0);
    rd_check("R2 no valid ignored", 3'd1, 32'h0000_0201);
  endtask

  task automatic t_capture();
    // Log already holds the event from t_counts: clear first so this one is first.
    cycle(0, 0, 0, '0, '0, '0, 1, 3'd0, 2'b01);
    rd_check("R7 log cleared", 3'd2, 32'h0);
    rd_check("R7 data zeroed", 3'd3, 32'h0);
    cycle(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFA5, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    rd_check("R5 log valid", 3'd2, 32'h1);
    rd_check("R8 data low", 3'd3, 32'h0000_00A5);
    rd_check("R8 data high", 3'd4, 32'h0);
    rd_check("R8 check bits", 3'd5, 32'h0000_001F);
    rd_check("R9 mask low", 3'd6, 32'h0000_00FF);
    rd_check("R9 mask high", 3'd7, 32'h0);
    cycle(1, 0, 1, 64'h0000_0000_0000_003C, 8'h02, 64'h1, 0, 0, 0);
    rd_check("R6 data frozen", 3'd3, 32'h0000_00A5);
    rd_check("R6 check frozen", 3'd5, 32'h0000_001F);
    rd_check("R6 mask frozen", 3'd6, 32'h0000_00FF);
  endtask

  task automatic t_clear();
    // counts now: corr 2, uncorr 2
    rd_check("R2 counts before clear", 3'd1, 32'h0000_0202);
    cycle(0, 0, 0, '0, '0, '0, 1, 3'd0, 2'b10);
    rd_check("R4 corr only cleared", 3'd1, 32'h0000_0002);
    rd_check("R4 log untouched", 3'd2, 32'h1);
    cycle(0, 0, 0, '0, '0, '0, 1, 3'd0, 2'b01);
    rd_check("R4 uncorr cleared", 3'd1, 32'h0);
    rd_check("R7 log rearmed", 3'd2, 32'h0);
    cycle(1, 0, 1, 64'h3C, 8'h0A, 64'h4, 0, 0, 0);
    rd_check("R7 new capture data", 3'd3, 32'h0000_003C);
    rd_check("R7 new capture check", 3'd5, 32'h0000_000A);
    rd_check("R7 new capture mask", 3'd6, 32'h0000_0004);
  endtask

  task automatic t_collision();
    clear_all();
    cycle(1, 1, 1, 64'h77, 8'h01, 64'h1, 1, 3'd0, 2'b01);
    rd_check("R10 uncorr dropped, corr counted", 3'd1, 32'h0000_0100);
    rd_check("R10 no capture", 3'd2, 32'h0);
    cycle(1, 1, 0, '0, '0, '0, 1, 3'd0, 2'b10);
    rd_check("R10 corr dropped", 3'd1, 32'h0);
  endtask

  task automatic t_ignored_writes();
    cycle(1, 1, 1, 64'h12, 8'h03, 64'h2, 0, 0, 0);
    for (int a = 1; a < 8; a++) cycle(0, 0, 0, '0, '0, '0, 1, 3'(a), 2'b11);
    rd_check("R11 other writes ignored stat", 3'd1, 32'h0000_0101);
    rd_check("R11 other writes ignored log", 3'd3, 32'h0000_0012);
    rd_check("R11 ctrl reads zero", 3'd0, 32'h0);
  endtask

  task automatic t_saturate();
    clear_all();
    @(negedge clk);
    ev_valid = 1; ev_corr = 1; ev_uncorr = 1; ev_data = 64'h5A; ev_check = 8'h1; ev_mask = 64'h8;
    repeat (300) @(negedge clk);
    ev_valid = 0; ev_corr = 0; ev_uncorr = 0;
    rd_check("R3 both saturated", 3'd1, 32'h0000_FFFF);
    rd_check("R6 first of burst kept", 3'd3, 32'h0000_005A);
    cycle(1, 1, 1, '0, '0, '0, 0, 0, 0);
    rd_check("R3 stays at 255", 3'd1, 32'h0000_FFFF);
    cycle(0, 0, 0, '0, '0, '0, 1, 3'd0, 2'b10);
    rd_check("R4 saturated corr cleared alone", 3'd1, 32'h0000_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counts();
    t_capture();
    t_clear();
    t_collision();
    t_ignored_writes();
    t_saturate();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule